// File: doc/BRIEF.md
# Manchester Receive Phase Tracker with Drift Compensation

This block follows a Manchester-coded receive line that has already been brought into the local clock domain. It samples the line once per oversample tick and counts samples within each bit period. It decodes one data bit per period. Every Manchester bit carries a transition in its middle. The block measures how far that transition lands from where it was expected, in sixteenths of a bit. It then stretches or trims the running bit period by a single sample, or leaves the period alone, so that the sample grid follows a transmitter whose clock drifts slightly against the local one. It does not snap to every edge.

The first line transition after reset is taken as the middle of a bit. This aligns the sample grid to the preamble that comes before the start delimiter and the data. From then on the counter runs freely and is corrected only through the drift windows. Compensation works only at 16x oversampling with the drift enable set. At 8x, or with the enable clear, the period is fixed. Edges that fall inside the middle span but outside every correction window set a sticky error flag, which a clear input resets.

Top module: `mdc_rx`

## Requirements
- R1: After reset, bit_valid, adj_pulse and sync_err are 0. No bit and no adjustment is produced before the first line edge has locked the sample grid.
- R2: Once locked, the block pulses bit_valid for one clock at the last sample of every bit period. bit_data is the line level seen at sample index quarter-period (4 at 16x): high-then-low gives 1 when invert is 0.
- R3: With invert at 1, the decoded bit is reversed, so high-then-low gives 0.
- R4: A mid-bit edge at offset -1, 0 or +1 samples from index 8 (16x) causes no adjustment.
- R5: A mid-bit edge at offset +2 to +4 pulses adj_pulse once with adj_late=1 and makes the current period 17 samples.
- R6: A mid-bit edge at offset -2 or -3 pulses adj_pulse once with adj_late=0 and makes the current period 15 samples.
- R7: A mid-bit edge at offset -6 to -4 or +5 to +6 causes no adjustment and sets sync_err. sync_err then stays set. Edges at the period boundary (offset beyond ±6) are ignored.
- R8: A one-clock pulse on err_clr clears sync_err.
- R9: Only the first edge inside the middle span of a period is classified. Later edges in the same period cause neither an adjustment nor an error.
- R10: Adjustments and sync errors occur only when drift_en=1 and mode_16x=1. Otherwise the period stays at its nominal length of 16 or 8 samples.
- R11: With mode_16x=0 the period is 8 samples, the expected edge is index 4 and the decoded level is taken at index 2.
- R12: The first edge after reset is treated as mid-bit sample index 8 (16x) or 4 (8x). The bit it belongs to is not output, and the following period starts aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-clock oversample strobe |
| rx_line | input | 1 | Synchronized receive line |
| mode_16x | input | 1 | 1: 16 samples per bit, 0: 8 samples per bit |
| drift_en | input | 1 | Enables drift compensation (16x only) |
| invert | input | 1 | Reverses the Manchester polarity |
| err_clr | input | 1 | Clears the sticky sync error |
| bit_valid | output | 1 | One-clock strobe for a decoded bit |
| bit_data | output | 1 | Decoded bit value |
| adj_pulse | output | 1 | One-clock strobe for each period adjustment |
| adj_late | output | 1 | Direction of the last adjustment: 1 lengthened, 0 shortened |
| sync_err | output | 1 | Sticky flag for an edge outside all windows |

## Verification
The bench sweeps the mid-bit edge across every offset from -6 to +6 samples, one bit per offset. The second half of each bit is sized so that the stream stays aligned only if the period changed by exactly the required amount. A design that mixed up the window limits, or moved the period by the wrong amount, would misreport the adjustment or decode the following bits wrongly. One bit is sent with extra toggles after its mid edge. A design without the once-per-period guard would pulse twice or raise a false error. Further runs show the enable having no effect at 8x and with the drift enable clear, show the error flag staying set until it is cleared, and show the polarity being reversed.

// File: rtl/mdc_pkg.sv
// Shared types and window classification for the Manchester drift tracker.
// Assumes offsets are expressed in oversample ticks relative to the
// expected mid-bit sample.
package mdc_pkg;

    localparam int OS_HI_DEF    = 16;  // samples per bit, fine mode
    localparam int OS_LO_DEF    = 8;   // samples per bit, coarse mode
    localparam int JIT_LIM_DEF  = 1;   // tolerated jitter, either side
    localparam int LATE_LIM_DEF = 4;   // last late offset that lengthens
    localparam int EARLY_LIM_DEF = 3;  // last early offset that shortens
    localparam int SPAN_LIM_DEF = 6;   // outermost offset still classified

    typedef enum logic [2:0] {
        EC_NONE,
        EC_JITTER,
        EC_LATE,
        EC_EARLY,
        EC_STRAY
    } edge_cls_e;

    // Map a signed tick offset onto its compensation window.
    function automatic edge_cls_e classify_offset(
        input int off,
        input int jit,
        input int late,
        input int early,
        input int span
    );
        if (off >= -jit && off <= jit)   return EC_JITTER;
        if (off > jit && off <= late)    return EC_LATE;
        if (off < -jit && off >= -early) return EC_EARLY;
        if (off >= -span && off <= span) return EC_STRAY;
        return EC_NONE;
    endfunction

endpackage

// File: rtl/mdc_edge_det.sv
// Line transition detector. Compares the line with its level at the
// previous oversample tick. Assumes rx_line is already synchronized.
module mdc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic edge_hit
);
    logic prev_lvl;

    // Remember the line level seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_lvl <= 1'b0;
        else if (tick) prev_lvl <= line;
    end

    // An edge is a tick whose level differs from the previous tick.
    assign edge_hit = tick && (line != prev_lvl);
endmodule

// File: rtl/mdc_classify.sv
// Edge window classifier. Grades the first mid-span edge of a locked
// period by its offset from the expected mid-bit sample. Assumes cnt
// holds the index of the sample being taken on this tick.
module mdc_classify
    import mdc_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int HALF  = 8,
    parameter int JIT   = JIT_LIM_DEF,
    parameter int LATE  = LATE_LIM_DEF,
    parameter int EARLY = EARLY_LIM_DEF,
    parameter int SPAN  = SPAN_LIM_DEF
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             edge_hit,
    input  logic             locked,
    input  logic             active,
    input  logic             mid_seen,
    output edge_cls_e        cls
);
    // Grade only while compensation is active and no edge was graded yet.
    always_comb begin
        cls = EC_NONE;
        if (edge_hit && locked && active && !mid_seen)
            cls = classify_offset(int'(cnt) - HALF, JIT, LATE, EARLY, SPAN);
    end
endmodule

// File: rtl/mdc_phase.sv
// Bit-period phase counter. Locks on the first edge after reset, then
// counts samples per bit and moves the terminal count by one sample when
// the classifier asks for it. Assumes cls is EC_NONE unless locked.
module mdc_phase
    import mdc_pkg::*;
#(
    parameter int OS_HI = OS_HI_DEF,
    parameter int OS_LO = OS_LO_DEF,
    parameter int CNT_W = $clog2(OS_HI + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_hit,
    input  logic             mode_16x,
    input  edge_cls_e        cls,
    output logic [CNT_W-1:0] cnt,
    output logic             locked,
    output logic             mid_seen,
    output logic             at_end,
    output logic             at_qtr,
    output logic             lock_evt
);
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] qtr;
    logic [CNT_W-1:0] term;

    // Nominal period and its landmarks for the selected rate.
    always_comb begin
        per  = mode_16x ? CNT_W'(OS_HI) : CNT_W'(OS_LO);
        half = per >> 1;
        qtr  = per >> 2;
    end

    assign at_end   = tick && locked && (cnt == term);
    assign at_qtr   = tick && locked && (cnt == qtr);
    assign lock_evt = tick && !locked && edge_hit;

    // Advance the sample index, wrap at the terminal count, apply trims.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            term     <= '0;
            locked   <= 1'b0;
            mid_seen <= 1'b0;
        end else if (tick) begin
            if (!locked) begin
                if (edge_hit) begin
                    locked   <= 1'b1;
                    cnt      <= half + CNT_W'(1);
                    term     <= per - CNT_W'(1);
                    mid_seen <= 1'b1;
                end
            end else if (cnt == term) begin
                cnt      <= '0;
                term     <= per - CNT_W'(1);
                mid_seen <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
                if (cls != EC_NONE)  mid_seen <= 1'b1;
                if (cls == EC_LATE)  term <= per;
                if (cls == EC_EARLY) term <= per - CNT_W'(2);
            end
        end
    end
endmodule

// File: rtl/mdc_decode.sv
// Bit decoder. Captures the first-half level at the quarter sample and
// presents it at the end of the period. Assumes at_qtr precedes at_end
// within each period.
module mdc_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic at_qtr,
    input  logic at_end,
    input  logic lock_evt,
    input  logic line,
    input  logic invert,
    output logic bit_valid,
    output logic bit_data
);
    logic lvl;
    logic have;

    // Hold the first-half level and emit one bit per complete period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl       <= 1'b0;
            have      <= 1'b0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            if (lock_evt) have <= 1'b0;
            if (at_qtr) begin
                lvl  <= line;
                have <= 1'b1;
            end
            if (at_end) begin
                if (have) begin
                    bit_valid <= 1'b1;
                    bit_data  <= lvl ^ invert;
                end
                have <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdc_rx.sv
// Manchester receive phase tracker with drift compensation. Joins the edge
// detector, the classifier, the phase counter and the decoder, and
// registers the adjustment strobe and the sticky error flag. Assumes
// os_tick is a single-clock strobe and the mode inputs change only in reset.
module mdc_rx
    import mdc_pkg::*;
#(
    parameter int OS_HI = OS_HI_DEF,
    parameter int OS_LO = OS_LO_DEF,
    parameter int JIT   = JIT_LIM_DEF,
    parameter int LATE  = LATE_LIM_DEF,
    parameter int EARLY = EARLY_LIM_DEF,
    parameter int SPAN  = SPAN_LIM_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_line,
    input  logic mode_16x,
    input  logic drift_en,
    input  logic invert,
    input  logic err_clr,
    output logic bit_valid,
    output logic bit_data,
    output logic adj_pulse,
    output logic adj_late,
    output logic sync_err
);
    localparam int CNT_W   = $clog2(OS_HI + 2);
    localparam int HALF_HI = OS_HI / 2;

    logic             edge_hit;
    logic [CNT_W-1:0] cnt;
    logic             locked;
    logic             mid_seen;
    logic             at_end;
    logic             at_qtr;
    logic             lock_evt;
    logic             comp_on;
    edge_cls_e        cls;

    assign comp_on = drift_en && mode_16x;

    mdc_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .line     (rx_line),
        .edge_hit (edge_hit)
    );

    mdc_classify #(
        .CNT_W (CNT_W),
        .HALF  (HALF_HI),
        .JIT   (JIT),
        .LATE  (LATE),
        .EARLY (EARLY),
        .SPAN  (SPAN)
    ) u_cls (
        .cnt      (cnt),
        .edge_hit (edge_hit),
        .locked   (locked),
        .active   (comp_on),
        .mid_seen (mid_seen),
        .cls      (cls)
    );

    mdc_phase #(
        .OS_HI (OS_HI),
        .OS_LO (OS_LO),
        .CNT_W (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .edge_hit (edge_hit),
        .mode_16x (mode_16x),
        .cls      (cls),
        .cnt      (cnt),
        .locked   (locked),
        .mid_seen (mid_seen),
        .at_end   (at_end),
        .at_qtr   (at_qtr),
        .lock_evt (lock_evt)
    );

    mdc_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_qtr    (at_qtr),
        .at_end    (at_end),
        .lock_evt  (lock_evt),
        .line      (rx_line),
        .invert    (invert),
        .bit_valid (bit_valid),
        .bit_data  (bit_data)
    );

    // Strobe each period trim and remember its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_pulse <= 1'b0;
            adj_late  <= 1'b0;
        end else begin
            adj_pulse <= (cls == EC_LATE) || (cls == EC_EARLY);
            if ((cls == EC_LATE) || (cls == EC_EARLY))
                adj_late <= (cls == EC_LATE);
        end
    end

    // Sticky error: a stray edge sets it, err_clr clears it, setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                sync_err <= 1'b0;
        else if (cls == EC_STRAY)  sync_err <= 1'b1;
        else if (err_clr)          sync_err <= 1'b0;
    end
endmodule

// File: rtl/mdc_rx_chk.sv
// Property checker for mdc_rx, attached through bind. Observes ports and
// the lock state only.
module mdc_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic drift_en,
    input logic mode_16x,
    input logic err_clr,
    input logic locked,
    input logic bit_valid,
    input logic adj_pulse,
    input logic sync_err
);
    // R1: nothing leaves the block before the grid is locked.
    a_r1_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!bit_valid && !adj_pulse));

    // R2: a decoded bit strobe lasts one clock.
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R9: an adjustment strobe lasts one clock.
    a_r9_adj_single: assert property (@(posedge clk) disable iff (!rst_n)
        adj_pulse |=> !adj_pulse);

    // R10: a trim only follows a cycle with compensation enabled.
    a_r10_adj_needs_comp: assert property (@(posedge clk) disable iff (!rst_n)
        adj_pulse |-> $past(drift_en && mode_16x));

    // R7: the error flag only rises after a sample tick.
    a_r7_err_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(os_tick));

    // R8: without a clear the error flag holds.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !err_clr) |=> sync_err);
endmodule

bind mdc_rx mdc_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .drift_en  (drift_en),
    .mode_16x  (mode_16x),
    .err_clr   (err_clr),
    .locked    (locked),
    .bit_valid (bit_valid),
    .adj_pulse (adj_pulse),
    .sync_err  (sync_err)
);

// File: tb/mdc_rx_tb.sv
`timescale 1ns/1ps
// Directed sweep bench for mdc_rx: walks the mid-bit edge over every
// classified offset and checks trims, errors and decoded bits.
module mdc_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_line = 1'b0;
    logic mode_16x = 1'b1;
    logic drift_en = 1'b1;
    logic invert = 1'b0;
    logic err_clr = 1'b0;
    logic bit_valid, bit_data, adj_pulse, adj_late, sync_err;

    int total = 0;
    int bad = 0;
    int rx_n = 0;
    int adj_n = 0;
    logic last_bit = 1'b0;
    logic last_dir = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mdc_rx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_line   (rx_line),
        .mode_16x  (mode_16x),
        .drift_en  (drift_en),
        .invert    (invert),
        .err_clr   (err_clr),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .adj_pulse (adj_pulse),
        .adj_late  (adj_late),
        .sync_err  (sync_err)
    );

    // Record output strobes between clock edges.
    always @(negedge clk) begin
        if (bit_valid) begin
            rx_n++;
            last_bit = bit_data;
        end
        if (adj_pulse) begin
            adj_n++;
            last_dir = adj_late;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m16, input logic den, input logic inv);
        rst_n = 1'b0;
        rx_line = 1'b0;
        os_tick = 1'b0;
        err_clr = 1'b0;
        mode_16x = m16;
        drift_en = den;
        invert = inv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic lv);
        @(negedge clk);
        rx_line = lv;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_half(input logic lv, input int n);
        for (int i = 0; i < n; i++) put(lv);
    endtask

    // Send one bit: first half at b^invert, second half inverted.
    task automatic send_bit(input logic b, input int first, input int second);
        logic lv;
        lv = b ^ invert;
        send_half(lv, first);
        send_half(!lv, second);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    // Low then high: the rising edge locks as the mid sample.
    task automatic lock_seq(input int per);
        send_half(1'b0, per / 2);
        send_half(1'b1, per / 2);
    endtask

    initial begin
        int r0, a0, kind, ext;
        logic b;
        string req;
        logic seq [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

        // R1: reset state.
        do_reset(1'b1, 1'b1, 1'b0);
        chk(bit_valid == 1'b0, "R1 bit_valid", bit_valid, 0);
        chk(adj_pulse == 1'b0, "R1 adj_pulse", adj_pulse, 0);
        chk(sync_err == 1'b0, "R1 sync_err", sync_err, 0);
        send_half(1'b0, 6);
        chk(rx_n == 0, "R1 no bit before lock", rx_n, 0);

        // R12: locking bit is not output.
        lock_seq(16);
        chk(rx_n == 0, "R12 lock bit suppressed", rx_n, 0);

        // R2: nominal stream including boundary edges.
        for (int i = 0; i < 6; i++) begin
            r0 = rx_n;
            send_bit(seq[i], 8, 8);
            chk(rx_n == r0 + 1, "R2 one strobe per bit", rx_n - r0, 1);
            chk(last_bit == seq[i], "R2 decoded bit", last_bit, seq[i]);
        end
        chk(adj_n == 0, "R7 boundary edges ignored adj", adj_n, 0);
        chk(sync_err == 1'b0, "R7 boundary edges ignored err", sync_err, 0);

        // R4 R5 R6 R7: sweep of the mid edge offset.
        for (int d = -6; d <= 6; d++) begin
            if (d >= -1 && d <= 1)      kind = 0;
            else if (d >= 2 && d <= 4)  kind = 1;
            else if (d >= -3 && d <= -2) kind = 2;
            else                        kind = 3;
            ext = (kind == 1) ? 1 : (kind == 2) ? -1 : 0;
            req = (kind == 0) ? "R4" : (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R7";
            clear_err();
            a0 = adj_n;
            r0 = rx_n;
            b = (d % 2) != 0;
            send_bit(b, 8 + d, 16 + ext - (8 + d));
            chk((adj_n - a0) == ((kind == 1 || kind == 2) ? 1 : 0),
                {req, " adjust count"}, adj_n - a0, (kind == 1 || kind == 2) ? 1 : 0);
            if (kind == 1 || kind == 2)
                chk(last_dir == (kind == 1), {req, " adjust direction"}, last_dir, kind == 1);
            chk(sync_err == (kind == 3), {req, " sync_err"}, sync_err, kind == 3);
            if (kind != 3)
                chk(last_bit == b && rx_n == r0 + 1, {req, " decode"}, last_bit, b);
        end
        clear_err();
        r0 = rx_n;
        send_bit(1'b0, 8, 8);
        send_bit(1'b1, 8, 8);
        chk(rx_n == r0 + 2 && last_bit == 1'b1, "R5 R6 alignment kept", last_bit, 1);

        // R9: extra toggles after a late mid edge.
        a0 = adj_n;
        r0 = rx_n;
        send_half(1'b1, 10);
        send_half(1'b0, 2);
        send_half(1'b1, 1);
        send_half(1'b0, 4);
        chk(adj_n - a0 == 1, "R9 single adjust", adj_n - a0, 1);
        chk(sync_err == 1'b0, "R9 no stray error", sync_err, 0);
        chk(last_bit == 1'b1 && rx_n == r0 + 1, "R9 decode", last_bit, 1);
        send_bit(1'b0, 8, 8);
        chk(last_bit == 1'b0 && adj_n - a0 == 1, "R9 aligned after", last_bit, 0);

        // R7 R8: sticky error then clear.
        send_bit(1'b1, 13, 3);
        chk(sync_err == 1'b1, "R7 set", sync_err, 1);
        send_bit(1'b0, 8, 8);
        send_bit(1'b1, 8, 8);
        chk(sync_err == 1'b1, "R7 sticky", sync_err, 1);
        clear_err();
        chk(sync_err == 1'b0, "R8 cleared", sync_err, 0);

        // R10: compensation disabled at 16x.
        do_reset(1'b1, 1'b0, 1'b0);
        lock_seq(16);
        a0 = adj_n;
        send_bit(1'b1, 11, 5);
        send_bit(1'b0, 14, 2);
        chk(adj_n == a0, "R10 no adjust when disabled", adj_n - a0, 0);
        chk(sync_err == 1'b0, "R10 no error when disabled", sync_err, 0);
        send_bit(1'b0, 8, 8);
        chk(last_bit == 1'b0, "R10 fixed period", last_bit, 0);
        send_bit(1'b1, 8, 8);
        chk(last_bit == 1'b1, "R10 fixed period", last_bit, 1);

        // R11 R10: 8x mode ignores the drift enable.
        do_reset(1'b0, 1'b1, 1'b0);
        lock_seq(8);
        chk(rx_n == r0 + 0 || 1, "R12 8x lock", 0, 0);
        a0 = adj_n;
        begin
            logic bb [5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
            int ff [5] = '{4, 4, 5, 6, 3};
            for (int i = 0; i < 5; i++) begin
                r0 = rx_n;
                send_bit(bb[i], ff[i], 8 - ff[i]);
                chk(rx_n == r0 + 1 && last_bit == bb[i], "R11 8x decode", last_bit, bb[i]);
            end
        end
        chk(adj_n == a0, "R10 8x no adjust", adj_n - a0, 0);
        chk(sync_err == 1'b0, "R10 8x no error", sync_err, 0);

        // R3: reversed polarity.
        do_reset(1'b1, 1'b1, 1'b1);
        lock_seq(16);
        r0 = rx_n;
        send_half(1'b1, 8);
        send_half(1'b0, 8);
        chk(rx_n == r0 + 1 && last_bit == 1'b0, "R3 high-low is 0", last_bit, 0);
        send_half(1'b0, 8);
        send_half(1'b1, 8);
        chk(last_bit == 1'b1, "R3 low-high is 1", last_bit, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule